// File: doc/BRIEF.md
# Posted-Write CPU Port for Video Memory

This block lets a processor reach video memory without ever being held off. The processor works through three registers. The address register points into video memory. The stride register sets how far the address moves after each write. The data register accepts a word to be written, and on read it returns the most recent word fetched from memory. A register access completes in the cycle it is presented. Memory is touched only in one dedicated slot. The slot is a single cycle that recurs once every fixed-length sequence of master clocks.

In every slot the port does one of two things. If no write is waiting, it reads the word at the current address and places it in the read latch. If a write is waiting, it stores the posted word at the current address and then advances the address by the stride, wrapping within the address space. A write posted while another is still waiting replaces the waiting word, so only one store is made. The slots run on their own sequence counter and have no handshake with the processor bus.

Top module: `vram_cpu_port`

## Requirements
- R1: After reset the address reads 0, the stride reads 1, the read latch reads 0, `wr_pending` is low and `mem_en` is low.
- R2: `mem_en` is high for exactly one cycle in every `SEQ_LEN` cycles. The first high cycle is the `SLOT_PHASE`-th cycle after reset is released, counting the release cycle as 0.
- R3: In a slot where no write is waiting, `mem_we` is low. The word that memory returns one cycle after the slot is held in the read latch from the cycle after that onward. The latch reads back on `cpu_rdata` when `cpu_reg` = 1.
- R4: A write with `cpu_reg` = 1 sets `wr_pending` from the next cycle. The next slot then drives `mem_we` high with that word on `mem_wdata` and the current address on `mem_addr`.
- R5: After a committed write, the address becomes (address + stride) modulo 2^`ADDR_W`.
- R6: A second data write made before the slot replaces the waiting word, and only one memory write takes place. `wr_pending` falls after the commit.
- R7: A write with `cpu_reg` = 0 loads the address from the low `ADDR_W` bits of `cpu_wdata`, and that load takes precedence over a same-cycle step. Without a commit or a load, the address holds.
- R8: Reading back with `cpu_reg` = 0 gives the address and with `cpu_reg` = 2 gives the stride, both zero-extended. `cpu_reg` = 2 writes the stride, and `cpu_reg` = 3 reads 0.
- R9: A data write made in the very cycle of a commit slot is kept. The slot stores the older word, `wr_pending` stays high, and the newer word is stored in the following slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Register access strobe |
| cpu_wr | input | 1 | Write qualifier for `cpu_sel` |
| cpu_reg | input | 2 | Register select: 0 address, 1 data, 2 stride, 3 none |
| cpu_wdata | input | DATA_W | Register write data |
| cpu_rdata | output | DATA_W | Register read data for `cpu_reg` (combinational) |
| wr_pending | output | 1 | A posted write is waiting for its slot |
| mem_en | output | 1 | Slot cycle: memory access this cycle |
| mem_we | output | 1 | Slot access is a write |
| mem_addr | output | ADDR_W | Current video memory address |
| mem_wdata | output | DATA_W | Posted write word |
| mem_rdata | input | DATA_W | Memory read word, valid one cycle after a read slot |

## Verification
The bench builds the port with `ADDR_W` = 8, `DATA_W` = 16, `SEQ_LEN` = 8 and `SLOT_PHASE` = 5, backed by a 256-word memory model of its own. The short sequence puts a slot within reach of every step, so the bench can aim a data write at the exact cycle of a commit (R9). The narrow address brings wrap-around within reach with small start values and strides (R5), and a stride of all ones acts as a step of minus one.

// File: rtl/vport_pkg.sv
package vport_pkg;

  // Register select codes seen on cpu_reg
  typedef enum logic [1:0] {
    VREG_ADDR = 2'd0,
    VREG_DATA = 2'd1,
    VREG_MOD  = 2'd2,
    VREG_NONE = 2'd3
  } vport_reg_e;

endpackage

// File: rtl/vport_seq_timer.sv
module vport_seq_timer #(
  parameter int SEQ_LEN    = 16,
  parameter int SLOT_PHASE = 13
) (
  input  logic clk,
  input  logic rst_n,
  output logic slot
);
  localparam int CNT_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(SEQ_LEN - 1);
  localparam logic [CNT_W-1:0] PHASE = CNT_W'(SLOT_PHASE);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign slot = (cnt_q == PHASE);
endmodule

// File: rtl/vport_rd_capture.sv
module vport_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_word
);
  // memory answers one cycle after the slot that issued the read
  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_issue;
  end

  assign rd_word = mem_rdata;
endmodule

// File: rtl/vport_regfile.sv
module vport_regfile
  import vport_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr,
  input  logic              data_wr,
  input  logic              mod_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              commit,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] mod_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rlatch_q,
  output logic              pend_q
);
  // address step with wrap inside the address space
  function automatic logic [ADDR_W-1:0] step_addr(
    input logic [ADDR_W-1:0] base,
    input logic [ADDR_W-1:0] stride
  );
    return base + stride;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_wr) addr_q <= cpu_wdata[ADDR_W-1:0];
    else if (commit)  addr_q <= step_addr(addr_q, mod_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      mod_q <= ADDR_W'(1);
    else if (mod_wr) mod_q <= cpu_wdata[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       wdata_q <= '0;
    else if (data_wr) wdata_q <= cpu_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (data_wr) pend_q <= 1'b1;
    else if (commit)  pend_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        rlatch_q <= '0;
    else if (rd_valid) rlatch_q <= rd_word;
  end
endmodule

// File: rtl/vram_cpu_port.sv
module vram_cpu_port
  import vport_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int SEQ_LEN    = 16,
  parameter int SLOT_PHASE = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_reg,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              wr_pending,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  // named internal events
  logic              evt_slot;
  logic              evt_addr_wr;
  logic              evt_data_wr;
  logic              evt_mod_wr;
  logic              evt_commit;
  logic              evt_rd_issue;
  logic              evt_rd_valid;
  logic [DATA_W-1:0] rd_word;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] mod_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rlatch_q;
  logic              pend_q;
  vport_reg_e        sel_reg;

  assign sel_reg     = vport_reg_e'(cpu_reg);
  assign evt_addr_wr = cpu_sel && cpu_wr && (sel_reg == VREG_ADDR);
  assign evt_data_wr = cpu_sel && cpu_wr && (sel_reg == VREG_DATA);
  assign evt_mod_wr  = cpu_sel && cpu_wr && (sel_reg == VREG_MOD);

  vport_seq_timer #(
    .SEQ_LEN    (SEQ_LEN),
    .SLOT_PHASE (SLOT_PHASE)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .slot (evt_slot)
  );

  assign evt_commit   = evt_slot && pend_q;
  assign evt_rd_issue = evt_slot && !pend_q;

  vport_rd_capture #(
    .DATA_W(DATA_W)
  ) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_issue (evt_rd_issue),
    .mem_rdata(mem_rdata),
    .rd_valid (evt_rd_valid),
    .rd_word  (rd_word)
  );

  vport_regfile #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_wr  (evt_addr_wr),
    .data_wr  (evt_data_wr),
    .mod_wr   (evt_mod_wr),
    .cpu_wdata(cpu_wdata),
    .commit   (evt_commit),
    .rd_valid (evt_rd_valid),
    .rd_word  (rd_word),
    .addr_q   (addr_q),
    .mod_q    (mod_q),
    .wdata_q  (wdata_q),
    .rlatch_q (rlatch_q),
    .pend_q   (pend_q)
  );

  always_comb begin
    unique case (sel_reg)
      VREG_ADDR: cpu_rdata = DATA_W'(addr_q);
      VREG_DATA: cpu_rdata = rlatch_q;
      VREG_MOD:  cpu_rdata = DATA_W'(mod_q);
      default:   cpu_rdata = '0;
    endcase
  end

  assign wr_pending = pend_q;
  assign mem_en     = evt_slot;
  assign mem_we     = evt_commit;
  assign mem_addr   = addr_q;
  assign mem_wdata  = wdata_q;
endmodule

// File: rtl/vram_cpu_port_chk.sv
module vram_cpu_port_chk #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int SEQ_LEN    = 16,
  parameter int SLOT_PHASE = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              wr_pending,
  input logic              evt_addr_wr,
  input logic              evt_data_wr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic [ADDR_W-1:0] mod_q
);
  localparam int GAP_W = $clog2(SEQ_LEN + SLOT_PHASE + 2) + 1;
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (mem_en) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != GAP_MAX) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  // R2
  slot_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && seen_q) |-> (gap_q == GAP_W'(SEQ_LEN - 1)));
  // R2
  first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !seen_q) |-> (gap_q == GAP_W'(SLOT_PHASE)));
  // R4
  we_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);
  // R4
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_data_wr |=> wr_pending);
  // R3
  read_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !wr_pending) |-> !mem_we);
  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !evt_addr_wr) |=> (mem_addr == ADDR_W'($past(mem_addr) + $past(mod_q))));
  // R6
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !evt_data_wr) |=> !wr_pending);
  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we && !evt_addr_wr) |=> $stable(mem_addr));
  // R7
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_addr_wr |=> (mem_addr == $past(cpu_wdata[ADDR_W-1:0])));
endmodule

bind vram_cpu_port vram_cpu_port_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .SEQ_LEN   (SEQ_LEN),
  .SLOT_PHASE(SLOT_PHASE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_en     (mem_en),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .wr_pending (wr_pending),
  .evt_addr_wr(evt_addr_wr),
  .evt_data_wr(evt_data_wr),
  .cpu_wdata  (cpu_wdata),
  .mod_q      (mod_q)
);

// File: tb/vram_cpu_port_bench.sv
module vram_cpu_port_bench;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int SL = 8;
  localparam int SP = 5;
  localparam int MEMN = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_sel = 1'b0;
  logic          cpu_wr = 1'b0;
  logic [1:0]    cpu_reg = 2'd3;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          wr_pending;
  logic          mem_en;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  logic [DW-1:0] bmem [MEMN];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vram_cpu_port #(
    .ADDR_W(AW), .DATA_W(DW), .SEQ_LEN(SL), .SLOT_PHASE(SP)
  ) u_vram_cpu_port (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_reg(cpu_reg), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .wr_pending(wr_pending), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // bench memory: synchronous, one cycle read latency
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEMN; i++) bmem[i] <= DW'(i * 37 + 16'h1200);
      mem_rdata <= '0;
    end else if (mem_en) begin
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      else        mem_rdata <= bmem[mem_addr];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // starts at a negedge, ends at the next negedge
  task automatic cpu_write(input logic [1:0] r, input logic [DW-1:0] d);
    cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_reg = r; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_wr = 1'b0; cpu_reg = 2'd3;
  endtask

  task automatic cpu_read(input logic [1:0] r, output logic [DW-1:0] d);
    cpu_reg = r;
    #1 d = cpu_rdata;
    cpu_reg = 2'd3;
  endtask

  // returns at the negedge inside the next slot cycle
  task automatic wait_slot();
    @(negedge clk);
    while (!mem_en) @(negedge clk);
  endtask

  // {start address, stride, data}
  localparam logic [31:0] VEC [6] = '{
    {8'h10, 8'h01, 16'hA5A5},
    {8'h33, 8'h00, 16'h0F0F},
    {8'hFE, 8'h03, 16'h1234},
    {8'h80, 8'hFF, 16'hBEEF},
    {8'h7F, 8'h81, 16'hFFFF},
    {8'h00, 8'h40, 16'h0000}
  };

  initial begin
    logic [DW-1:0] rd;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, sampled in the release cycle
    cpu_read(2'd0, rd); check("R1 addr", rd, 0);
    cpu_read(2'd2, rd); check("R1 stride", rd, 1);
    cpu_read(2'd1, rd); check("R1 latch", rd, 0);
    check("R1 pending", wr_pending, 0);
    check("R1 mem_en", mem_en, 0);

    // R2 first slot position
    n = 0;
    while (!mem_en) begin @(negedge clk); n++; end
    check("R2 first slot", n, SP);
    // R2 one slot per sequence
    n = 0;
    for (int k = 0; k < 5 * SL; k++) begin @(negedge clk); if (mem_en) n++; end
    check("R2 slot count", n, 5);

    // R8 register map
    cpu_write(2'd2, 16'h0007);
    cpu_read(2'd2, rd); check("R8 stride readback", rd, 16'h0007);
    cpu_read(2'd3, rd); check("R8 reg3 zero", rd, 0);

    // vector table: load, post, commit, refresh
    for (int v = 0; v < 6; v++) begin
      logic [AW-1:0] a, m, na;
      logic [DW-1:0] d;
      a = VEC[v][31:24]; m = VEC[v][23:16]; d = VEC[v][15:0];
      na = AW'((int'(a) + int'(m)) % MEMN);
      cpu_write(2'd0, DW'(a));
      cpu_write(2'd2, DW'(m));
      cpu_read(2'd0, rd); check("R7 addr load", rd, DW'(a));
      cpu_write(2'd1, d);
      check("R4 pending set", wr_pending, 1);
      wait_slot();
      check("R4 slot write", mem_we, 1);
      check("R4 slot addr", mem_addr, a);
      check("R4 slot data", mem_wdata, d);
      @(negedge clk); @(negedge clk);
      check("R4 memory", bmem[a], d);
      check("R6 pending cleared", wr_pending, 0);
      cpu_read(2'd0, rd); check("R5 stepped addr", rd, DW'(na));
      wait_slot();
      check("R3 read slot no we", mem_we, 0);
      @(negedge clk); @(negedge clk);
      cpu_read(2'd1, rd); check("R3 latch refresh", rd, bmem[na]);
      cpu_read(2'd0, rd); check("R7 addr held after read", rd, DW'(na));
    end

    // R3 plain read at a chosen address
    cpu_write(2'd0, 16'h0042);
    wait_slot();
    check("R3 read no we", mem_we, 0);
    @(negedge clk); @(negedge clk);
    cpu_read(2'd1, rd); check("R3 latch word", rd, bmem[8'h42]);

    // R6 overwrite before the slot
    cpu_write(2'd0, 16'h0010);
    cpu_write(2'd2, 16'h0002);
    wait_slot();
    cpu_write(2'd1, 16'hAAAA);
    cpu_write(2'd1, 16'hBBBB);
    wait_slot();
    check("R6 latest word", mem_wdata, 16'hBBBB);
    check("R6 write slot", mem_we, 1);
    @(negedge clk);
    cpu_read(2'd0, rd); check("R6 single step", rd, 16'h0012);
    wait_slot();
    check("R6 no second write", mem_we, 0);
    check("R6 memory", bmem[8'h10], 16'hBBBB);

    // R9 data write in the commit cycle
    cpu_write(2'd0, 16'h0020);
    cpu_write(2'd2, 16'h0004);
    cpu_write(2'd1, 16'hC001);
    wait_slot();
    check("R9 first commit", mem_wdata, 16'hC001);
    cpu_write(2'd1, 16'hC002);
    check("R9 still pending", wr_pending, 1);
    cpu_read(2'd0, rd); check("R9 addr stepped", rd, 16'h0024);
    wait_slot();
    check("R9 second write", mem_we, 1);
    check("R9 second addr", mem_addr, 8'h24);
    check("R9 second data", mem_wdata, 16'hC002);
    @(negedge clk);
    check("R9 first word kept", bmem[8'h20], 16'hC001);
    check("R9 second word", bmem[8'h24], 16'hC002);
    cpu_read(2'd0, rd); check("R5 after second step", rd, 16'h0028);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule